// File: doc/BRIEF.md
# Serial/Parallel Step Attenuator Controller

This block is the digital control front end of a six-bit binary step attenuator. A mode input picks the control source. In parallel mode, six direct inputs set the attenuation word. In serial mode, a three-wire port carries a data line, a shift clock and a latch strobe. Each rising shift-clock edge moves one bit into a six-bit shift register, most significant bit first. Raising the strobe copies the register into the holding latch that drives the attenuator.

The six control outputs are active-low. Bit k carries a weight of 2^k half-dB steps, so all ones gives the 0 dB reference and all zeros gives the full 31.5 dB. A serial output repeats the data input six shift edges later, so several controllers can be chained on one bus. A diagnostic output gives the current attenuation in half-dB units.

All serial lines are sampled by the system clock `clk`. A shift-clock edge is seen as a low sample followed by a high sample.

Top module: `step_atten_ctrl`

## Requirements
- R1: A synchronous reset sets all controls and the shift register to ones. One clock after reset, `ctl_n` is 6'b111111, `atten_half` is 0 and `ser_out` is 1.
- R2: With `mode_ser` low, `ctl_n` equals the `par_bits` value sampled at the previous clock edge.
- R3: With `mode_ser` low, activity on `ser_clk`, `ser_dat` and `ser_le` leaves `ctl_n` and `ser_out` unchanged.
- R4: With `mode_ser` high and `ser_le` low, each sampled rising edge of `ser_clk` shifts `ser_dat` into bit 0 while the other bits move up one place. After six edges, the first bit sent sits at bit 5.
- R5: With `mode_ser` high, every clock at which `ser_le` is high loads the shift register into the latch. The new value appears on `ctl_n` one clock later.
- R6: A `ser_clk` rising edge sampled while `ser_le` is high does not shift the register and does not change `ser_out`.
- R7: After `ser_le` falls, `ctl_n` holds its value while new bits are shifted in.
- R8: On each shifting edge, `ser_out` takes the old bit 5 of the shift register. It therefore repeats the bit sent six shifting edges earlier, and ones after reset.
- R9: `atten_half` is the bitwise inverse of `ctl_n`. A low `ctl_n[k]` adds 2^k half-dB steps.
- R10: When the block enters serial mode, `ctl_n` keeps its last parallel value until the next `ser_le` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| mode_ser | input | 1 | 1 = serial control, 0 = parallel control |
| par_bits | input | 6 | Active-low parallel control word |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; masks shifting while high |
| ctl_n | output | 6 | Active-low attenuation bit controls |
| atten_half | output | 6 | Current attenuation in 0.5 dB units |
| ser_out | output | 1 | Serial data delayed six shift edges |

## Verification
Shifting and latching can be requested in the same clock: a `ser_clk` rising edge can arrive in the cycle where `ser_le` goes high. The bench provokes this right after a full word has been shifted in. The latch must take the unshifted word, and `ser_out` must not move. The extra bit must also be missing from the next committed word. The bench also makes the strobe fall in the same cycle as a clock edge, which checks that shifting resumes there while the latch holds.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
    localparam int CTL_W = 6;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } ctl_mode_e;

    // active-low control word to attenuation count in half-dB units
    function automatic logic [CTL_W-1:0] ctl_to_half(input logic [CTL_W-1:0] ctl);
        return ~ctl;
    endfunction
endpackage

// File: rtl/sa_edge_det.sv
module sa_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sa_shift.sv
module sa_shift #(
    parameter int W = step_atten_pkg::CTL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         dat_i,
    input  logic         le_i,
    output logic [W-1:0] sr_o,
    output logic         so_o
);
    logic [W-1:0] sr_q;
    logic         so_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '1;
            so_q <= 1'b1;
        end else if (shift_i) begin
            so_q <= sr_q[W-1];
            sr_q <= {sr_q[W-2:0], dat_i};
        end
    end

    assign sr_o = sr_q;
    assign so_o = so_q;

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        le_i |=> ($stable(sr_q) && $stable(so_q)));

    // R8
    ser_out_chk: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (so_q == $past(sr_q[W-1])));

    // R4
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (sr_q[0] == $past(dat_i)));
endmodule

// File: rtl/sa_latch.sv
module sa_latch
    import step_atten_pkg::*;
#(
    parameter int W = CTL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_mode_e    mode_i,
    input  logic         le_i,
    input  logic [W-1:0] sr_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '1;
        end else if (mode_i == MODE_PAR) begin
            q_r <= par_i;
        end else if (le_i) begin
            q_r <= sr_i;
        end
    end

    assign q_o = q_r;

    // R2
    par_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_PAR) |=> (q_r == $past(par_i)));

    // R5
    le_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SER && le_i) |=> (q_r == $past(sr_i)));

    // R7
    le_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SER && !le_i) |=> $stable(q_r));

    // R1
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (q_r == '1));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import step_atten_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_ser,
    input  logic [CTL_W-1:0] par_bits,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_le,
    output logic [CTL_W-1:0] ctl_n,
    output logic [CTL_W-1:0] atten_half,
    output logic             ser_out
);
    localparam int W = CTL_W;

    ctl_mode_e    mode;
    logic         sclk_rise;
    logic         shift_en;
    logic [W-1:0] sr_word;
    logic [W-1:0] lat_word;

    assign mode = mode_ser ? MODE_SER : MODE_PAR;

    sa_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (ser_clk),
        .rise_o (sclk_rise)
    );

    assign shift_en = sclk_rise & ~ser_le & (mode == MODE_SER);

    sa_shift #(.W(W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift_en),
        .dat_i   (ser_dat),
        .le_i    (ser_le),
        .sr_o    (sr_word),
        .so_o    (ser_out)
    );

    sa_latch #(.W(W)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .le_i   (ser_le),
        .sr_i   (sr_word),
        .par_i  (par_bits),
        .q_o    (lat_word)
    );

    assign ctl_n      = lat_word;
    assign atten_half = ctl_to_half(lat_word);

    // R9
    atten_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (atten_half ^ ctl_n) == '1);

    // R3
    par_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_ser |=> $stable(ser_out));
endmodule

// File: tb/tb_step_atten_ctrl.sv
module tb_step_atten_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_ser;
    logic [5:0] par_bits;
    logic       ser_clk;
    logic       ser_dat;
    logic       ser_le;
    logic [5:0] ctl_n;
    logic [5:0] atten_half;
    logic       ser_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_atten_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .mode_ser   (mode_ser),
        .par_bits   (par_bits),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .ser_le     (ser_le),
        .ctl_n      (ctl_n),
        .atten_half (atten_half),
        .ser_out    (ser_out)
    );

    typedef struct {
        string      tag;
        logic [5:0] ctl;
        logic       so;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;

    // bench model state
    logic [5:0] m_sr, m_lat;
    logic       m_so, m_scp;
    logic [5:0] cur_par = 6'b111111;

    task automatic push(input string tag);
        exp_t e;
        e.tag = tag;
        e.ctl = m_lat;
        e.so  = m_so;
        q.push_back(e);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; mode_ser = 1'b0; par_bits = cur_par;
        ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b0;
        m_sr = '1; m_lat = '1; m_so = 1'b1; m_scp = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        push(tag);
    endtask

    task automatic step(input logic ps, input logic sc, input logic sd,
                        input logic le, input logic [5:0] par, input string tag);
        logic rise;
        mode_ser = ps; ser_clk = sc; ser_dat = sd; ser_le = le; par_bits = par;
        rise = sc & ~m_scp;
        m_scp = sc;
        if (ps) begin
            if (le) m_lat = m_sr;
            else if (rise) begin
                m_so = m_sr[5];
                m_sr = {m_sr[4:0], sd};
            end
        end else begin
            m_lat = par;
        end
        @(posedge clk);
        #1;
        push(tag);
    endtask

    task automatic shift_word(input logic [5:0] w, input string tag);
        for (int i = 5; i >= 0; i--) begin
            step(1'b1, 1'b0, w[i], 1'b0, cur_par, tag);
            step(1'b1, 1'b1, w[i], 1'b0, cur_par, tag);
        end
    endtask

    // monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (ctl_n !== e.ctl) begin
                    bad++;
                    $display("FAIL %s ctl_n act=%b exp=%b", e.tag, ctl_n, e.ctl);
                end
                total++;
                if (atten_half !== ~e.ctl) begin
                    bad++;
                    $display("FAIL R9 (%s) atten_half act=%0d exp=%0d", e.tag, atten_half, ~e.ctl);
                end
                total++;
                if (ser_out !== e.so) begin
                    bad++;
                    $display("FAIL %s ser_out act=%b exp=%b", e.tag, ser_out, e.so);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        do_reset("R1 reset");

        // parallel mode
        cur_par = 6'b101010; step(1'b0, 1'b0, 1'b0, 1'b0, cur_par, "R2 par a");
        cur_par = 6'b000000; step(1'b0, 1'b0, 1'b0, 1'b0, cur_par, "R2 par max R9");
        cur_par = 6'b111110; step(1'b0, 1'b0, 1'b0, 1'b0, cur_par, "R2 par half-dB R9");
        cur_par = 6'b011111; step(1'b0, 1'b0, 1'b0, 1'b0, cur_par, "R2 par 16dB R9");

        // serial activity in parallel mode
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, i[0], 1'b0, cur_par, "R3 sclk high");
            step(1'b0, 1'b0, i[0], 1'b1, cur_par, "R3 le high");
        end

        // enter serial mode: hold last parallel value
        step(1'b1, 1'b0, 1'b0, 1'b0, cur_par, "R10 enter serial");
        step(1'b1, 1'b0, 1'b0, 1'b0, cur_par, "R10 hold");

        // shift a word; ser_out shows reset ones
        shift_word(6'b011010, "R4 R8 shift word1");
        step(1'b1, 1'b0, 1'b0, 1'b1, cur_par, "R5 latch word1");
        step(1'b1, 1'b0, 1'b0, 1'b1, cur_par, "R5 latch transparent");
        step(1'b1, 1'b0, 1'b0, 1'b0, cur_par, "R7 le fall");

        // second word: latch holds, ser_out replays word1
        shift_word(6'b100101, "R7 R8 shift word2");

        // rising edge in same cycle as strobe: masked
        step(1'b1, 1'b0, 1'b1, 1'b0, cur_par, "R6 prep");
        step(1'b1, 1'b1, 1'b1, 1'b1, cur_par, "R6 edge with le");
        step(1'b1, 1'b0, 1'b1, 1'b1, cur_par, "R6 le held");
        step(1'b1, 1'b1, 1'b1, 1'b1, cur_par, "R6 second masked edge");
        // strobe falls while clock rises: shift resumes, latch holds
        step(1'b1, 1'b0, 1'b0, 1'b1, cur_par, "R6 low clk");
        step(1'b1, 1'b1, 1'b0, 1'b0, cur_par, "R7 le fall with edge");
        step(1'b1, 1'b0, 1'b0, 1'b1, cur_par, "R5 latch shifted");

        // serial all-zero word: full attenuation
        step(1'b1, 1'b0, 1'b0, 1'b0, cur_par, "R4 prep");
        shift_word(6'b000000, "R4 R8 shift zeros");
        step(1'b1, 1'b0, 1'b0, 1'b1, cur_par, "R5 R9 latch zeros");
        step(1'b1, 1'b0, 1'b0, 1'b0, cur_par, "R7 hold zeros");

        // reset from non-default state
        do_reset("R1 reset again");
        step(1'b0, 1'b0, 1'b0, 1'b0, cur_par, "R2 after reset");

        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule